// File: doc/BRIEF.md
# Serial Channel Modem-Line Controller

This block drives and watches the handshake lines of one synchronous serial channel. It sits between a bit-level transmitter/receiver and the device pins. It produces the active-low request-to-send output and gates the transmitter with the active-low clear-to-send input. It also raises an interrupt when clear-to-send changes level, and it compares the bit being transmitted with the level on the shared bus to detect collisions.

The request-to-send line has four sources, chosen by a two-bit select. In software mode a control bit drives the line, and the line is released only after the transmitter has drained. In bus-transmit mode the line follows the outgoing frame one bit time late and skips collision-check bits. In bus-receive mode it follows frame reception. In the fourth mode the line is held off. Every bus mode also switches the transmit-data pin to open-drain drive.

Top module: `modem_line_ctl`

## Requirements
- R1: With `rts_sel` = 2'b00 (software mode) and `sw_rts` = 1, `rts_n` is 0 after the next clock edge.
- R2: In software mode with `sw_rts` = 0, `rts_n` returns to 1 only on an edge where `tx_idle` = 1 and `tx_req_pending` = 0. Until then it keeps its value.
- R3: With `rts_sel` = 2'b01 (bus transmit), `rts_n` changes only at edges where `ser_bit_en` = 1. It then becomes 0 if `tx_frame_active` = 1 and `tx_chk_bit` = 0, and 1 otherwise. This gives a delay of one bit time.
- R4: With `rts_sel` = 2'b10 (bus receive), `rts_n` after each edge is the inverse of `rx_frame_active` sampled at that edge.
- R5: With `rts_sel` = 2'b11 (off), `rts_n` is 1 after the next edge, whatever the other inputs are.
- R6: `tx_enable` is the inverse of `cts_pin` after a two-flop synchronizer. It is 0 while the synchronized level is 1, and 0 out of reset.
- R7: When `cts_irq_en` = 1, every change of the synchronized CTS level gives a one-cycle `cts_irq` pulse and sets `cts_chg`. With `cts_irq_en` = 0 neither is raised. `cts_clr` = 1 clears `cts_chg`.
- R8: In any bus mode (`rts_sel` != 2'b00), an edge with `ser_bit_en` = 1, `txd_bit` = 1 and a synchronized `cxd_pin` of 0 sets the sticky `coll_flag`. In software mode the flag is never set. `coll_clr` = 1 clears the flag, and a new collision in the same cycle wins over the clear.
- R9: `txd_od` is 1 exactly while `rts_sel` != 2'b00.
- R10: While `rst_n` = 0, `rts_n` = 1 and `tx_enable`, `cts_irq`, `cts_chg` and `coll_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rts | input | 1 | Software request-to-send bit |
| rts_sel | input | 2 | RTS source: 00 software, 01 bus transmit, 10 bus receive, 11 off |
| cts_irq_en | input | 1 | Enables CTS change interrupts |
| cts_clr | input | 1 | Clears the sticky CTS change bit |
| coll_clr | input | 1 | Clears the sticky collision flag |
| tx_frame_active | input | 1 | Transmitter is shifting a frame |
| tx_chk_bit | input | 1 | Current transmit bit is a collision-check bit |
| tx_idle | input | 1 | Transmitter has finished |
| tx_req_pending | input | 1 | Another transmission is requested |
| rx_frame_active | input | 1 | Receiver is inside a data frame |
| ser_bit_en | input | 1 | One-cycle strobe at the end of each serial bit time |
| txd_bit | input | 1 | Bit currently driven on transmit data |
| cts_pin | input | 1 | Asynchronous clear-to-send pin, active low |
| cxd_pin | input | 1 | Asynchronous shared-bus collision data pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_enable | output | 1 | Transmitter may shift |
| cts_irq | output | 1 | One-cycle CTS change interrupt |
| cts_chg | output | 1 | Sticky CTS change status |
| coll_flag | output | 1 | Sticky collision flag |
| txd_od | output | 1 | 1 selects open-drain drive for transmit data |

## Verification
The RTS source is walked through a table of patterns. In software mode, set and clear are combined with a draining or busy transmitter, which separates "release at once" from "release after drain". In bus-transmit mode, frame and check-bit levels are changed with and without the bit strobe, which shows that the line moves only at strobes and skips check bits. Receive and off modes run with conflicting inputs raised. Directed cases then toggle CTS with the interrupt enabled and disabled. They also try collisions with the transmit bit at 1 and at 0, and in software mode, where no collision may be flagged.

// File: rtl/mdm_pkg.sv
// Shared types of the modem-line controller.
package mdm_pkg;
    // RTS source select; encoding is visible at the rts_sel port.
    typedef enum logic [1:0] {
        RTS_SW  = 2'b00,
        RTS_TXB = 2'b01,
        RTS_RXB = 2'b10,
        RTS_OFF = 2'b11
    } rts_src_e;
endpackage

// File: rtl/mdm_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes inputs are quasi-static relative to clk; RST_VAL sets the idle level.
module mdm_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mdm_rts_gen.sv
// Request-to-send generator: picks one of four sources and registers the pin.
// Assumes ser_bit_en is a single-cycle strobe per serial bit.
module mdm_rts_gen
    import mdm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rts_src_e src,
    input  logic     sw_rts,
    input  logic     tx_idle,
    input  logic     tx_req_pending,
    input  logic     tx_frame_active,
    input  logic     tx_chk_bit,
    input  logic     rx_frame_active,
    input  logic     ser_bit_en,
    output logic     rts_n
);
    logic rts_act_q;
    logic rts_act_d;

    // Next request level for the selected source.
    always_comb begin
        rts_act_d = rts_act_q;
        unique case (src)
            RTS_SW: begin
                if (sw_rts)
                    rts_act_d = 1'b1;
                else if (tx_idle && !tx_req_pending)
                    rts_act_d = 1'b0;
            end
            RTS_TXB: begin
                if (ser_bit_en)
                    rts_act_d = tx_frame_active && !tx_chk_bit;
            end
            RTS_RXB: rts_act_d = rx_frame_active;
            RTS_OFF: rts_act_d = 1'b0;
            default: rts_act_d = 1'b0;
        endcase
    end

    // Hold the request level; reset releases the line.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_act_q <= 1'b0;
        else        rts_act_q <= rts_act_d;
    end

    assign rts_n = ~rts_act_q;
endmodule

// File: rtl/mdm_cts_mon.sv
// CTS monitor: transmit gating and change interrupt from the synchronized level.
// Assumes cts_s is already synchronized to clk.
module mdm_cts_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_s,
    input  logic irq_en,
    input  logic clr,
    output logic tx_enable,
    output logic irq,
    output logic chg
);
    logic cts_prev;
    logic edge_seen;

    assign edge_seen = cts_s ^ cts_prev;

    // Remember the previous level; reset assumes the line is idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_prev <= 1'b1;
        else        cts_prev <= cts_s;
    end

    // Pulse and sticky status on any enabled transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            chg <= 1'b0;
        end else begin
            irq <= irq_en && edge_seen;
            if (irq_en && edge_seen) chg <= 1'b1;
            else if (clr)            chg <= 1'b0;
        end
    end

    assign tx_enable = ~cts_s;
endmodule

// File: rtl/mdm_coll_det.sv
// Collision detector: compares the driven bit with the bus level at bit end.
// Assumes bit time spans at least the synchronizer depth plus one cycle.
module mdm_coll_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic bit_en,
    input  logic txd_bit,
    input  logic cxd_s,
    input  logic clr,
    output logic flag
);
    logic hit;

    assign hit = bus_mode && bit_en && txd_bit && !cxd_s;

    // Sticky flag; a new collision wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/modem_line_ctl.sv
// Modem-line controller top: RTS generation, CTS gating/interrupt,
// collision sensing and TXD drive-type select for one serial channel.
// Assumes cts_pin and cxd_pin are asynchronous; all else is clk-synchronous.
module modem_line_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_rts,
    input  logic [1:0] rts_sel,
    input  logic       cts_irq_en,
    input  logic       cts_clr,
    input  logic       coll_clr,
    input  logic       tx_frame_active,
    input  logic       tx_chk_bit,
    input  logic       tx_idle,
    input  logic       tx_req_pending,
    input  logic       rx_frame_active,
    input  logic       ser_bit_en,
    input  logic       txd_bit,
    input  logic       cts_pin,
    input  logic       cxd_pin,
    output logic       rts_n,
    output logic       tx_enable,
    output logic       cts_irq,
    output logic       cts_chg,
    output logic       coll_flag,
    output logic       txd_od
);
    localparam int NPINS = 2;

    rts_src_e         src;
    logic             bus_mode;
    logic [NPINS-1:0] pins_s;

    assign src      = rts_src_e'(rts_sel);
    assign bus_mode = (src != RTS_SW);
    assign txd_od   = bus_mode;

    mdm_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cxd_pin, cts_pin}), .q_sync(pins_s)
    );

    mdm_rts_gen u_rts (
        .clk(clk), .rst_n(rst_n), .src(src), .sw_rts(sw_rts),
        .tx_idle(tx_idle), .tx_req_pending(tx_req_pending),
        .tx_frame_active(tx_frame_active), .tx_chk_bit(tx_chk_bit),
        .rx_frame_active(rx_frame_active), .ser_bit_en(ser_bit_en),
        .rts_n(rts_n)
    );

    mdm_cts_mon u_cts (
        .clk(clk), .rst_n(rst_n), .cts_s(pins_s[0]), .irq_en(cts_irq_en),
        .clr(cts_clr), .tx_enable(tx_enable), .irq(cts_irq), .chg(cts_chg)
    );

    mdm_coll_det u_coll (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .bit_en(ser_bit_en),
        .txd_bit(txd_bit), .cxd_s(pins_s[1]), .clr(coll_clr), .flag(coll_flag)
    );
endmodule

// File: rtl/modem_line_ctl_chk.sv
// Property checker for modem_line_ctl, attached by bind.
module modem_line_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rts,
    input logic [1:0] rts_sel,
    input logic       cts_irq_en,
    input logic       tx_idle,
    input logic       tx_req_pending,
    input logic       rx_frame_active,
    input logic       ser_bit_en,
    input logic       rts_n,
    input logic       cts_irq,
    input logic       coll_flag
);
    p_sw_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_sel == 2'b00 && sw_rts) |=> !rts_n);

    p_sw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_sel == 2'b00 && !sw_rts && !(tx_idle && !tx_req_pending)) |=> $stable(rts_n));

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_sel == 2'b01 && !ser_bit_en) |=> $stable(rts_n));

    p_rx_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_sel == 2'b10) |=> (rts_n == !$past(rx_frame_active)));

    p_off_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_sel == 2'b11) |=> rts_n);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |-> $past(cts_irq_en));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |=> !cts_irq);

    p_coll_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(ser_bit_en && rts_sel != 2'b00));
endmodule

bind modem_line_ctl modem_line_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rts(sw_rts), .rts_sel(rts_sel),
    .cts_irq_en(cts_irq_en), .tx_idle(tx_idle), .tx_req_pending(tx_req_pending),
    .rx_frame_active(rx_frame_active), .ser_bit_en(ser_bit_en),
    .rts_n(rts_n), .cts_irq(cts_irq), .coll_flag(coll_flag)
);

// File: tb/tb_modem_line_ctl.sv
// Bench: RTS vector table walk, then directed reset, CTS and collision cases.
module tb_modem_line_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_rts = 0, cts_irq_en = 0, cts_clr = 0, coll_clr = 0;
    logic [1:0] rts_sel = 2'b00;
    logic tx_frame_active = 0, tx_chk_bit = 0, tx_idle = 1, tx_req_pending = 0;
    logic rx_frame_active = 0, ser_bit_en = 0, txd_bit = 0;
    logic cts_pin = 1, cxd_pin = 1;
    logic rts_n, tx_enable, cts_irq, cts_chg, coll_flag, txd_od;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    modem_line_ctl dut (.*);

    // {sel[1:0], sw, idle, req, frame, chk, rx, bit_en, expected rts_n}
    localparam int NV = 17;
    localparam logic [9:0] VEC [NV] = '{
        10'b00_1_0_0_0_0_0_0_0, // R1 set
        10'b00_0_0_0_0_0_0_0_0, // R2 busy: hold low
        10'b00_0_1_1_0_0_0_0_0, // R2 idle but pending: hold
        10'b00_0_1_0_0_0_0_0_1, // R2 drained: release
        10'b10_0_0_0_0_0_1_0_0, // R4 receiving
        10'b10_0_0_0_0_0_0_0_1, // R4 not receiving
        10'b01_0_0_0_1_0_0_0_1, // R3 no strobe: hold
        10'b01_0_0_0_1_0_0_1_0, // R3 strobe: assert
        10'b01_0_0_0_1_1_0_1_1, // R3 check bit: release
        10'b01_0_0_0_1_0_0_0_1, // R3 no strobe: hold
        10'b01_0_0_0_1_0_0_1_0, // R3 strobe again
        10'b01_0_0_0_0_0_0_0_0, // R3 frame ended, held one bit
        10'b01_0_0_0_0_0_0_1_1, // R3 released at strobe
        10'b00_1_0_0_0_0_0_0_0, // R1 set again
        10'b11_1_0_0_1_0_1_1_1, // R5 off despite requests
        10'b11_0_0_0_0_0_1_0_1, // R5 off
        10'b00_0_1_0_0_0_0_0_1  // R2 release
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        // R10 reset state
        check("R10", rts_n, 1'b1);
        check("R10", tx_enable, 1'b0);
        check("R10", cts_irq, 1'b0);
        check("R10", cts_chg, 1'b0);
        check("R10", coll_flag, 1'b0);
        check("R9", txd_od, 1'b0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            {rts_sel, sw_rts, tx_idle, tx_req_pending, tx_frame_active,
             tx_chk_bit, rx_frame_active, ser_bit_en} = VEC[i][9:1];
            tick();
            ser_bit_en = 1'b0;
            check($sformatf("R1-5 vec%0d", i), rts_n, VEC[i][0]);
        end
        sw_rts = 0; tx_frame_active = 0; tx_chk_bit = 0; rx_frame_active = 0;

        // R9 drive select in each mode
        rts_sel = 2'b01; #1 check("R9", txd_od, 1'b1);
        rts_sel = 2'b10; #1 check("R9", txd_od, 1'b1);
        rts_sel = 2'b00; #1 check("R9", txd_od, 1'b0);

        // R6 / R7 CTS falling with interrupt enabled
        cts_irq_en = 1; cts_pin = 0;
        tick();
        check("R6", tx_enable, 1'b0);
        tick();
        check("R6", tx_enable, 1'b1);
        check("R7", cts_irq, 1'b0);
        tick();
        check("R7", cts_irq, 1'b1);
        tick();
        check("R7", cts_irq, 1'b0);
        check("R7", cts_chg, 1'b1);
        cts_clr = 1; tick(); cts_clr = 0;
        check("R7", cts_chg, 1'b0);
        // R7 rising edge with interrupt disabled: no pulse, no status
        cts_irq_en = 0; cts_pin = 1;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R7 disabled", cts_irq, 1'b0);
        end
        check("R7 disabled", cts_chg, 1'b0);
        check("R6", tx_enable, 1'b0);

        // R8 collision in bus mode
        rts_sel = 2'b01; txd_bit = 1; cxd_pin = 0;
        tick(3);
        check("R8", coll_flag, 1'b0);
        ser_bit_en = 1; tick(); ser_bit_en = 0;
        check("R8", coll_flag, 1'b1);
        coll_clr = 1; tick(); coll_clr = 0;
        check("R8 clear", coll_flag, 1'b0);
        // R8 clear loses to a simultaneous collision
        coll_clr = 1; ser_bit_en = 1; tick(); coll_clr = 0; ser_bit_en = 0;
        check("R8 priority", coll_flag, 1'b1);
        coll_clr = 1; tick(); coll_clr = 0;
        // R8 driving 0: no collision
        txd_bit = 0; ser_bit_en = 1; tick(); ser_bit_en = 0;
        check("R8 txd0", coll_flag, 1'b0);
        // R8 software mode: never flagged
        rts_sel = 2'b00; txd_bit = 1; ser_bit_en = 1; tick(); ser_bit_en = 0;
        check("R8 sw mode", coll_flag, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule